// File: doc/BRIEF.md
# Debug Trigger and Run Control Unit

This block sits beside a small CPU core and watches its bus traffic for a debugger. Every access the core makes (an instruction fetch, an internal data memory access, an external data memory access or a special-function-register access) is presented on one snoop port together with a domain code. A set of comparator slots is loaded through a register-write port. Each slot holds an address, an optional data pattern and qualifiers for reads and writes. When an enabled slot matches a snooped access, the block raises a registered halt request to the core. It also records which slot caused the stop.

A slot in the program domain acts as a breakpoint on a fetch address. A slot in any of the three data domains acts as a watchpoint. The host drives a small command port to halt, resume, single-step or skip one instruction. The block reports whether the core is executing and whether the debugger currently owns the bus. When no slot is enabled, the block stops capturing snoop traffic, so the comparators stay quiet.

Top module: `dbg_trigger_unit`

## Requirements
- R1: After reset, `cpu_halt`=0, `core_run`=1, `cpu_skip`=0, `dbg_acc`=0, `hit_valid`=0, `hit_slot`=0, `match_idle`=1, and every slot is disabled.
- R2: Domain code 0 is program fetch. An enabled slot with domain 0 matches any fetch at its address, whatever the data, the data-compare bit and the read/write qualifiers. An access presented before edge k raises `cpu_halt` after edge k+1.
- R3: In domains 1 (internal data), 2 (external data) and 3 (SFR), `bus_wr`=1 marks a write and 0 a read. A read matches only if the slot's read qualifier is set, and a write matches only if its write qualifier is set.
- R4: In the data domains, a slot with data compare set matches only when `bus_data` equals its pattern. A slot with data compare clear matches any data.
- R5: A slot never matches an access whose domain code differs from its own, even at the same address.
- R6: `cpu_halt` stays high until a run command. Command codes are 0 halt, 1 run, 2 step and 3 skip. The halt command stops the core from any state. Matches are ignored while halted, and a command in the same cycle takes precedence over a match.
- R7: A step command issued while halted drops `cpu_halt`. The first `insn_done` pulse after that raises it again at the next edge. A step command issued while running has no effect.
- R8: A skip command issued while halted gives a one-cycle `cpu_skip` pulse after the next edge, and `cpu_halt` stays high throughout. A skip command issued while running gives no pulse.
- R9: A halt caused by a match sets `hit_valid` and loads `hit_slot` with the lowest matching slot index. A halt caused by the halt command or by step completion clears `hit_valid` and leaves `hit_slot` unchanged.
- R10: `core_run` is the inverse of `cpu_halt` at all times.
- R11: `dbg_acc` follows `host_acc` one cycle later. Accesses flagged with `host_acc` never cause a match.
- R12: `match_idle` is high exactly when no slot is enabled. While it is high, no snooped access can halt the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for one slot |
| cfg_sel | input | 2 | Slot index to write |
| cfg_en | input | 1 | Slot enable |
| cfg_dom | input | 2 | Slot domain code |
| cfg_addr | input | 16 | Slot address |
| cfg_data | input | 8 | Slot data pattern |
| cfg_dcmp | input | 1 | Slot data-compare enable |
| cfg_rd | input | 1 | Slot matches reads |
| cfg_wr | input | 1 | Slot matches writes |
| bus_vld | input | 1 | Snooped access present |
| bus_dom | input | 2 | Domain code of snooped access |
| bus_addr | input | 16 | Address of snooped access |
| bus_data | input | 8 | Data of snooped access |
| bus_wr | input | 1 | Snooped access is a write |
| host_acc | input | 1 | Access is performed by the debugger |
| cmd_vld | input | 1 | Host command strobe |
| cmd_op | input | 2 | Host command code |
| insn_done | input | 1 | Core finished one instruction |
| cpu_halt | output | 1 | Halt request to the core |
| cpu_skip | output | 1 | Advance past the current instruction without executing it |
| core_run | output | 1 | Core is executing |
| dbg_acc | output | 1 | Debugger owns the bus |
| hit_valid | output | 1 | Last halt came from a slot |
| hit_slot | output | 2 | Slot that caused the last match halt |
| match_idle | output | 1 | No slot enabled, matching idle |

## Verification
The hardest situations to reach are the ones where several conditions coincide. One is an access that agrees with a slot in all fields but one. Another is two slots matching the same access. A third is a step that must let exactly one completion pulse through. The stimulus loads slots with chosen domains, qualifiers and patterns. It then presents accesses that differ from a matching one in only the domain, the direction or the data, which isolates each qualifier. It also programs two identical slots to show which index wins. Step, skip and halt commands are issued both while halted and while running. Completion pulses are sent both before and after a step.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
  // domain codes decoded by the slot comparators
  typedef enum logic [1:0] {
    DOM_PROG  = 2'd0,
    DOM_IDATA = 2'd1,
    DOM_XDATA = 2'd2,
    DOM_SFR   = 2'd3
  } dom_e;

  typedef enum logic [1:0] {
    CMD_HALT = 2'd0,
    CMD_RUN  = 2'd1,
    CMD_STEP = 2'd2,
    CMD_SKIP = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_STEP = 2'd2
  } run_st_e;
endpackage

// File: rtl/dtu_slot.sv
module dtu_slot
  import dtu_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int IW  = 2,
  parameter int IDX = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_sel,
  input  logic          cfg_en,
  input  logic [1:0]    cfg_dom,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_data,
  input  logic          cfg_dcmp,
  input  logic          cfg_rd,
  input  logic          cfg_wr,
  input  logic          snp_vld,
  input  logic [1:0]    snp_dom,
  input  logic [AW-1:0] snp_addr,
  input  logic [DW-1:0] snp_data,
  input  logic          snp_wr,
  output logic          slot_en,
  output logic          hit
);
  logic          en_q, dc_q, rd_q, wr_q;
  dom_e          dom_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          addr_eq, kind_ok, data_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      dom_q  <= DOM_PROG;
      addr_q <= '0;
      data_q <= '0;
      dc_q   <= 1'b0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
    end else if (cfg_we && cfg_sel == IW'(IDX)) begin
      en_q   <= cfg_en;
      dom_q  <= dom_e'(cfg_dom);
      addr_q <= cfg_addr;
      data_q <= cfg_data;
      dc_q   <= cfg_dcmp;
      rd_q   <= cfg_rd;
      wr_q   <= cfg_wr;
    end
  end

  always_comb begin
    addr_eq = snp_vld && en_q && (snp_dom == dom_q) && (snp_addr == addr_q);
    if (dom_q == DOM_PROG) begin
      // fetch breakpoint: address only
      kind_ok = 1'b1;
      data_ok = 1'b1;
    end else begin
      kind_ok = snp_wr ? wr_q : rd_q;
      data_ok = !dc_q || (snp_data == data_q);
    end
  end

  assign hit     = addr_eq && kind_ok && data_ok;
  assign slot_en = en_q;

  // R5: a hit always belongs to the slot's own domain
  p_dom_match_r5: assert property (@(posedge clk) disable iff (rst)
    hit |-> (snp_dom == dom_q));
endmodule

// File: rtl/dtu_ctrl.sv
module dtu_ctrl
  import dtu_pkg::*;
#(
  parameter int NSLOTS = 4,
  parameter int IW     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_vld,
  input  logic [1:0]        cmd_op,
  input  logic              insn_done,
  input  logic              host_acc,
  input  logic [NSLOTS-1:0] hit_vec,
  output logic              cpu_halt,
  output logic              cpu_skip,
  output logic              core_run,
  output logic              dbg_acc,
  output logic              hit_valid,
  output logic [IW-1:0]     hit_slot
);
  run_st_e       st_q;
  logic          skip_q, dbg_q, hv_q;
  logic [IW-1:0] hs_q, first_idx;
  cmd_e          op;

  assign op = cmd_e'(cmd_op);

  // lowest index wins
  always_comb begin
    first_idx = '0;
    for (int i = NSLOTS - 1; i >= 0; i--) begin
      if (hit_vec[i]) first_idx = IW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_RUN;
      skip_q <= 1'b0;
      dbg_q  <= 1'b0;
      hv_q   <= 1'b0;
      hs_q   <= '0;
    end else begin
      skip_q <= 1'b0;
      dbg_q  <= host_acc;
      if (cmd_vld) begin
        case (op)
          CMD_HALT: begin
            st_q <= ST_HALT;
            hv_q <= 1'b0;
          end
          CMD_RUN:  st_q <= ST_RUN;
          CMD_STEP: if (st_q == ST_HALT) st_q <= ST_STEP;
          CMD_SKIP: if (st_q == ST_HALT) skip_q <= 1'b1;
          default:  ;
        endcase
      end else if (st_q != ST_HALT && |hit_vec) begin
        st_q <= ST_HALT;
        hv_q <= 1'b1;
        hs_q <= first_idx;
      end else if (st_q == ST_STEP && insn_done) begin
        st_q <= ST_HALT;
        hv_q <= 1'b0;
      end
    end
  end

  assign cpu_halt  = (st_q == ST_HALT);
  assign core_run  = (st_q != ST_HALT);
  assign cpu_skip  = skip_q;
  assign dbg_acc   = dbg_q;
  assign hit_valid = hv_q;
  assign hit_slot  = hs_q;

  p_halt_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HALT && !cmd_vld) |=> cpu_halt);
  p_skip_halted_r8: assert property (@(posedge clk) disable iff (rst)
    cpu_skip |-> cpu_halt);
  p_step_done_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_STEP && insn_done && !cmd_vld) |=> cpu_halt);
  p_hit_flag_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(hit_valid) |-> cpu_halt);
endmodule

// File: rtl/dbg_trigger_unit.sv
module dbg_trigger_unit
  import dtu_pkg::*;
#(
  parameter int NSLOTS = 4,
  parameter int AW     = 16,
  parameter int DW     = 8,
  localparam int IW    = $clog2(NSLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_sel,
  input  logic          cfg_en,
  input  logic [1:0]    cfg_dom,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_data,
  input  logic          cfg_dcmp,
  input  logic          cfg_rd,
  input  logic          cfg_wr,
  input  logic          bus_vld,
  input  logic [1:0]    bus_dom,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          bus_wr,
  input  logic          host_acc,
  input  logic          cmd_vld,
  input  logic [1:0]    cmd_op,
  input  logic          insn_done,
  output logic          cpu_halt,
  output logic          cpu_skip,
  output logic          core_run,
  output logic          dbg_acc,
  output logic          hit_valid,
  output logic [IW-1:0] hit_slot,
  output logic          match_idle
);
  logic              snp_vld, snp_wr;
  logic [1:0]        snp_dom;
  logic [AW-1:0]     snp_addr;
  logic [DW-1:0]     snp_data;
  logic [NSLOTS-1:0] en_vec, hit_vec;

  assign match_idle = ~|en_vec;

  // snoop capture, frozen while no slot is enabled
  always_ff @(posedge clk) begin
    if (rst) begin
      snp_vld  <= 1'b0;
      snp_wr   <= 1'b0;
      snp_dom  <= '0;
      snp_addr <= '0;
      snp_data <= '0;
    end else begin
      snp_vld <= bus_vld && !host_acc && !match_idle;
      if (bus_vld && !match_idle) begin
        snp_wr   <= bus_wr;
        snp_dom  <= bus_dom;
        snp_addr <= bus_addr;
        snp_data <= bus_data;
      end
    end
  end

  for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
    dtu_slot #(.AW(AW), .DW(DW), .IW(IW), .IDX(g)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .cfg_we   (cfg_we),
      .cfg_sel  (cfg_sel),
      .cfg_en   (cfg_en),
      .cfg_dom  (cfg_dom),
      .cfg_addr (cfg_addr),
      .cfg_data (cfg_data),
      .cfg_dcmp (cfg_dcmp),
      .cfg_rd   (cfg_rd),
      .cfg_wr   (cfg_wr),
      .snp_vld  (snp_vld),
      .snp_dom  (snp_dom),
      .snp_addr (snp_addr),
      .snp_data (snp_data),
      .snp_wr   (snp_wr),
      .slot_en  (en_vec[g]),
      .hit      (hit_vec[g])
    );
  end

  dtu_ctrl #(.NSLOTS(NSLOTS), .IW(IW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmd_vld   (cmd_vld),
    .cmd_op    (cmd_op),
    .insn_done (insn_done),
    .host_acc  (host_acc),
    .hit_vec   (hit_vec),
    .cpu_halt  (cpu_halt),
    .cpu_skip  (cpu_skip),
    .core_run  (core_run),
    .dbg_acc   (dbg_acc),
    .hit_valid (hit_valid),
    .hit_slot  (hit_slot)
  );

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    match_idle |=> (hit_vec == '0));
  p_host_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_vld && host_acc) |=> !snp_vld);
endmodule

// File: tb/dbg_trigger_unit_bench.sv
`timescale 1ns/1ps
module dbg_trigger_unit_bench;
  localparam int NSL = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we, cfg_en, cfg_dcmp, cfg_rd, cfg_wr;
  logic [1:0]  cfg_sel, cfg_dom;
  logic [15:0] cfg_addr;
  logic [7:0]  cfg_data;
  logic        bus_vld, bus_wr, host_acc;
  logic [1:0]  bus_dom;
  logic [15:0] bus_addr;
  logic [7:0]  bus_data;
  logic        cmd_vld, insn_done;
  logic [1:0]  cmd_op;
  logic        cpu_halt, cpu_skip, core_run, dbg_acc, hit_valid, match_idle;
  logic [1:0]  hit_slot;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  dbg_trigger_unit u_dbg_trigger_unit (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_en(cfg_en), .cfg_dom(cfg_dom),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_dcmp(cfg_dcmp),
    .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
    .bus_vld(bus_vld), .bus_dom(bus_dom), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_wr(bus_wr), .host_acc(host_acc),
    .cmd_vld(cmd_vld), .cmd_op(cmd_op), .insn_done(insn_done),
    .cpu_halt(cpu_halt), .cpu_skip(cpu_skip), .core_run(core_run),
    .dbg_acc(dbg_acc), .hit_valid(hit_valid), .hit_slot(hit_slot),
    .match_idle(match_idle)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_en[NSL], m_dom[NSL], m_addr[NSL], m_dat[NSL], m_dc[NSL], m_rd[NSL], m_wr[NSL];
  int m_pv, m_pdom, m_paddr, m_pdata, m_pwr;
  int m_st;   // 0 running, 1 halted, 2 stepping
  int m_skip, m_hv, m_hs, m_dbg;
  bit mdl_ok = 1'b0;

  function automatic bit m_hit(int i);
    if (m_en[i] == 0 || m_pv == 0) return 1'b0;
    if (m_pdom != m_dom[i] || m_paddr != m_addr[i]) return 1'b0;
    if (m_dom[i] == 0) return 1'b1;
    if (m_pwr != 0 ? m_wr[i] == 0 : m_rd[i] == 0) return 1'b0;
    if (m_dc[i] != 0 && m_pdata != m_dat[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit m_idle();
    for (int i = 0; i < NSL; i++) if (m_en[i] != 0) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    int first;
    bit idle;
    if (rst) begin
      for (int i = 0; i < NSL; i++) begin
        m_en[i] = 0; m_dom[i] = 0; m_addr[i] = 0; m_dat[i] = 0;
        m_dc[i] = 0; m_rd[i] = 0; m_wr[i] = 0;
      end
      m_pv = 0; m_pdom = 0; m_paddr = 0; m_pdata = 0; m_pwr = 0;
      m_st = 0; m_skip = 0; m_hv = 0; m_hs = 0; m_dbg = 0;
      mdl_ok = 1'b1;
    end else begin
      first = -1;
      for (int i = NSL - 1; i >= 0; i--) if (m_hit(i)) first = i;
      idle = m_idle();
      m_skip = 0;
      m_dbg = int'(host_acc);
      if (cmd_vld) begin
        if (cmd_op == 2'd0) begin m_st = 1; m_hv = 0; end
        else if (cmd_op == 2'd1) m_st = 0;
        else if (cmd_op == 2'd2) begin if (m_st == 1) m_st = 2; end
        else begin if (m_st == 1) m_skip = 1; end
      end else if (m_st != 1 && first >= 0) begin
        m_st = 1; m_hv = 1; m_hs = first;
      end else if (m_st == 2 && insn_done) begin
        m_st = 1; m_hv = 0;
      end
      m_pv = int'(bus_vld && !host_acc && !idle);
      if (bus_vld && !idle) begin
        m_pdom = int'(bus_dom); m_paddr = int'(bus_addr);
        m_pdata = int'(bus_data); m_pwr = int'(bus_wr);
      end
      if (cfg_we) begin
        m_en[cfg_sel] = int'(cfg_en); m_dom[cfg_sel] = int'(cfg_dom);
        m_addr[cfg_sel] = int'(cfg_addr); m_dat[cfg_sel] = int'(cfg_data);
        m_dc[cfg_sel] = int'(cfg_dcmp); m_rd[cfg_sel] = int'(cfg_rd);
        m_wr[cfg_sel] = int'(cfg_wr);
      end
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && mdl_ok) begin
      chk(32'(cpu_halt),   32'(m_st == 1), "R6 model cpu_halt");
      chk(32'(core_run),   32'(m_st != 1), "R10 model core_run");
      chk(32'(cpu_skip),   32'(m_skip),    "R8 model cpu_skip");
      chk(32'(dbg_acc),    32'(m_dbg),     "R11 model dbg_acc");
      chk(32'(hit_valid),  32'(m_hv),      "R9 model hit_valid");
      chk(32'(hit_slot),   32'(m_hs),      "R9 model hit_slot");
      chk(32'(match_idle), 32'(m_idle()),  "R12 model match_idle");
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic set_slot(input int sel, input bit en, input int dom, input int addr,
                          input int data, input bit dc, input bit rd, input bit wr);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_en = en; cfg_dom = 2'(dom);
    cfg_addr = 16'(addr); cfg_data = 8'(data); cfg_dcmp = dc; cfg_rd = rd; cfg_wr = wr;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // returns when the halt decision for this access is visible
  task automatic access(input int dom, input int addr, input int data, input bit wr, input bit host);
    bus_vld = 1'b1; bus_dom = 2'(dom); bus_addr = 16'(addr);
    bus_data = 8'(data); bus_wr = wr; host_acc = host;
    @(negedge clk);
    if (host) chk(32'(dbg_acc), 32'd1, "R11 dbg_acc after host access");
    bus_vld = 1'b0; host_acc = 1'b0;
    @(negedge clk);
  endtask

  task automatic command(input int op);
    cmd_vld = 1'b1; cmd_op = 2'(op);
    @(negedge clk);
    cmd_vld = 1'b0;
  endtask

  task automatic done_pulse();
    insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    cfg_we = 0; cfg_sel = 0; cfg_en = 0; cfg_dom = 0; cfg_addr = 0; cfg_data = 0;
    cfg_dcmp = 0; cfg_rd = 0; cfg_wr = 0;
    bus_vld = 0; bus_dom = 0; bus_addr = 0; bus_data = 0; bus_wr = 0; host_acc = 0;
    cmd_vld = 0; cmd_op = 0; insn_done = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(32'(cpu_halt), 0, "R1 halt"); chk(32'(core_run), 1, "R1 run");
    chk(32'(cpu_skip), 0, "R1 skip"); chk(32'(hit_valid), 0, "R1 hit_valid");
    chk(32'(match_idle), 1, "R1 idle"); chk(32'(dbg_acc), 0, "R1 dbg");

    // R2 fetch breakpoint, qualifiers clear
    set_slot(1, 1, 0, 'h0100, 'h00, 0, 0, 0);
    chk(32'(match_idle), 0, "R12 idle drops with an enabled slot");
    access(0, 'h0101, 'h00, 0, 0);
    chk(32'(cpu_halt), 0, "R2 near-miss fetch");
    access(0, 'h0100, 'h77, 0, 0);
    chk(32'(cpu_halt), 1, "R2 fetch breakpoint");
    chk(32'(hit_valid), 1, "R9 match sets flag");
    chk(32'(hit_slot), 1, "R9 slot index");
    chk(32'(core_run), 0, "R10 not running");

    // R6 matches ignored while halted
    set_slot(0, 1, 0, 'h0200, 'h00, 0, 0, 0);
    access(0, 'h0200, 'h00, 0, 0);
    chk(32'(hit_slot), 1, "R6 match ignored while halted");
    command(1);
    chk(32'(cpu_halt), 0, "R6 run clears halt");

    // R3/R4/R5 data watchpoint on slot 0
    set_slot(0, 1, 1, 'h0040, 'h5A, 1, 1, 0);
    access(1, 'h0040, 'h11, 0, 0);
    chk(32'(cpu_halt), 0, "R4 data mismatch");
    access(1, 'h0040, 'h5A, 1, 0);
    chk(32'(cpu_halt), 0, "R3 write not enabled");
    access(2, 'h0040, 'h5A, 0, 0);
    chk(32'(cpu_halt), 0, "R5 other domain");
    access(1, 'h0040, 'h5A, 0, 0);
    chk(32'(cpu_halt), 1, "R4 data match halts");
    chk(32'(hit_slot), 0, "R9 slot 0");
    command(1);

    // R9 lowest index, R11 host access, R4 no data compare
    set_slot(2, 1, 3, 'h0080, 'h00, 0, 0, 1);
    set_slot(3, 1, 3, 'h0080, 'h00, 0, 0, 1);
    access(3, 'h0080, 'h33, 0, 0);
    chk(32'(cpu_halt), 0, "R3 read not enabled");
    access(3, 'h0080, 'h33, 1, 1);
    chk(32'(cpu_halt), 0, "R11 host access never matches");
    access(3, 'h0080, 'h99, 1, 0);
    chk(32'(cpu_halt), 1, "R4 any data without compare");
    chk(32'(hit_slot), 2, "R9 lowest slot wins");

    // R9 halt command clears flag, keeps slot
    command(0);
    chk(32'(cpu_halt), 1, "R6 halt command");
    chk(32'(hit_valid), 0, "R9 halt command clears flag");
    chk(32'(hit_slot), 2, "R9 slot kept");

    // R7 single step
    command(2);
    chk(32'(cpu_halt), 0, "R7 step releases");
    repeat (3) @(negedge clk);
    chk(32'(cpu_halt), 0, "R7 waits for completion");
    done_pulse();
    chk(32'(cpu_halt), 1, "R7 halts after one instruction");
    done_pulse();
    chk(32'(cpu_halt), 1, "R7 stays halted");
    command(1);
    command(2);
    chk(32'(cpu_halt), 0, "R7 step while running");
    done_pulse();
    chk(32'(cpu_halt), 0, "R7 step ignored while running");

    // R8 skip
    command(0);
    command(3);
    chk(32'(cpu_skip), 1, "R8 skip pulse");
    chk(32'(cpu_halt), 1, "R8 halt held");
    @(negedge clk);
    chk(32'(cpu_skip), 0, "R8 pulse one cycle");
    command(1);
    command(3);
    chk(32'(cpu_skip), 0, "R8 skip ignored while running");

    // R12 idle
    for (int i = 0; i < NSL; i++) set_slot(i, 0, 0, 'h0100, 'h00, 0, 0, 0);
    chk(32'(match_idle), 1, "R12 idle with no slot");
    access(0, 'h0100, 'h00, 0, 0);
    chk(32'(cpu_halt), 0, "R12 no halt while idle");

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule